// File: doc/BRIEF.md
# Reed-Solomon Codeword Encoder for a Transcoded Ethernet Line

This block adds forward error correction to a line-coded Ethernet physical layer without raising the line rate. Upstream logic delivers 257-bit transcoded blocks, each of which carries four 66-bit line blocks. The encoder gathers twenty of these blocks into a 5140-bit message. It cuts the message into 514 ten-bit symbols and appends fourteen parity symbols of a shortened Reed-Solomon code over GF(2^10). The result is a 528-symbol (5280-bit) codeword. That is the same bit count as the eighty 66-bit blocks it replaces, so turning the code on leaves the line rate unchanged.

The encoder does not look at what the blocks contain. Idles, control characters, preamble and frame data are all protected in the same way, and codeword boundaries have no relation to packet boundaries. The input is a valid/ready stream of blocks. The output is a valid/ready stream of symbols: first the message symbols in arrival order, then the parity. Downstream logic (scrambling, lane distribution, alignment) consumes the symbols.

Top module: `rsfec_encoder`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high.
- R2: Every codeword on the output is exactly 528 symbols: 514 message symbols followed by 14 parity symbols.
- R3: Message symbols are packed in arrival order, least significant bit first, with packing carried across block boundaries. Message bit b is bit (b mod 257) of the (b div 257)-th block of the codeword. Output message symbol k holds message bits 10k to 10k+9, with bit 10k in symbol bit 0.
- R4: The parity symbols form a valid code word with the message. The field is built from x^10 + x^3 + 1 with alpha = x. Taking the first output symbol as the highest-degree coefficient, the 528-symbol polynomial evaluates to zero at alpha^0 through alpha^13.
- R5: Exactly 20 blocks are accepted per codeword. `in_ready` stays low from the acceptance of the 20th block until the cycle after the last parity symbol is taken.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_sym` holds its value on the next cycle.
- R7: A message of all zero bits yields fourteen zero parity symbols. No content is treated specially.
- R8: Each codeword depends only on its own twenty blocks. Sending the same twenty blocks twice in a row gives the same parity both times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A transcoded block is offered |
| in_ready | output | 1 | The encoder takes the offered block this cycle |
| in_block | input | 257 | Transcoded block, bit 0 first in line order |
| out_valid | output | 1 | A codeword symbol is offered |
| out_ready | input | 1 | Downstream takes the offered symbol this cycle |
| out_sym | output | 10 | Codeword symbol |

## Verification
The bench builds the encoder with its default values: 257-bit blocks, twenty blocks per codeword and fourteen parity symbols. These are the only values that give a whole number of ten-bit symbols and the line-rate match. With them, the bench reaches the cases where a block boundary falls in the middle of a symbol, the exact drain of the packing buffer at the last message symbol, and the handover from one codeword to the next. The message patterns used are random, all zeros, all ones, a repeated message and a single set bit at each block start. The bench runs some of them with the output held off at irregular intervals. Parity is checked by an independent syndrome computation rather than by a second encoder.

// File: rtl/rsfec_pkg.sv
package rsfec_pkg;

  // Symbol width and the field polynomial x^10 + x^3 + 1
  localparam int SYM_W = 10;
  localparam logic [SYM_W:0] FIELD_POLY = 11'h409;
  // Number of parity symbols per codeword
  localparam int PAR_N = 14;

  typedef logic [SYM_W-1:0] sym_t;
  typedef sym_t [PAR_N:0]   gen_t;

  localparam sym_t POLY_LOW = FIELD_POLY[SYM_W-1:0];

  // General field product, MSB-first shift-and-add
  function automatic sym_t gf_mul(sym_t a, sym_t b);
    sym_t r;
    r = '0;
    for (int i = SYM_W - 1; i >= 0; i--) begin
      r = r[SYM_W-1] ? ((r << 1) ^ POLY_LOW) : (r << 1);
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  // Generator polynomial coefficients: product of (x + alpha^i), i = 0 .. PAR_N-1
  function automatic gen_t gen_poly();
    gen_t g;
    sym_t root;
    g    = '0;
    g[0] = sym_t'(1);
    root = sym_t'(1);
    for (int i = 0; i < PAR_N; i++) begin
      for (int j = PAR_N; j > 0; j--) begin
        g[j] = g[j-1] ^ gf_mul(g[j], root);
      end
      g[0] = gf_mul(g[0], root);
      root = gf_mul(root, sym_t'(2));
    end
    return g;
  endfunction

endpackage

// File: rtl/rsfec_packer.sv
module rsfec_packer
  import rsfec_pkg::*;
#(
  parameter int BLK_W = 257,
  parameter int BLKS  = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blk_valid,
  output logic             blk_ready,
  input  logic [BLK_W-1:0] blk_data,
  output logic             sym_valid,
  output sym_t             sym_data,
  input  logic             sym_pop,
  input  logic             cw_end
);

  localparam int ACC_W  = BLK_W + SYM_W - 1;
  localparam int CNT_W  = $clog2(ACC_W + 1);
  localparam int BCNT_W = $clog2(BLKS + 1);

  logic [ACC_W-1:0]  acc_q, acc_d, acc_rem;
  logic [CNT_W-1:0]  fill_q, fill_d, fill_rem;
  logic [BCNT_W-1:0] nblk_q, nblk_d;
  logic              pop, take;

  // Next-state logic
  always_comb begin
    sym_valid = (fill_q >= CNT_W'(SYM_W));
    sym_data  = acc_q[SYM_W-1:0];
    pop       = sym_valid && sym_pop;
    fill_rem  = pop ? (fill_q - CNT_W'(SYM_W)) : fill_q;
    acc_rem   = pop ? (acc_q >> SYM_W) : acc_q;
    blk_ready = (nblk_q < BCNT_W'(BLKS)) && (fill_rem < CNT_W'(SYM_W));
    take      = blk_valid && blk_ready;

    acc_d  = acc_rem;
    fill_d = fill_rem;
    nblk_d = nblk_q;
    if (take) begin
      acc_d  = acc_rem | ({{(SYM_W-1){1'b0}}, blk_data} << fill_rem);
      fill_d = fill_rem + CNT_W'(BLK_W);
      nblk_d = nblk_q + BCNT_W'(1);
    end
    if (cw_end) nblk_d = '0;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      fill_q <= '0;
      nblk_q <= '0;
    end else begin
      if (pop || take) begin
        acc_q  <= acc_d;
        fill_q <= fill_d;
      end
      if (take || cw_end) nblk_q <= nblk_d;
    end
  end

  // R3
  fill_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= CNT_W'(ACC_W));

  // R2
  drained_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cw_end |-> (fill_q == '0) && (nblk_q == BCNT_W'(BLKS)));

endmodule

// File: rtl/rsfec_parity_lfsr.sv
module rsfec_parity_lfsr
  import rsfec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic absorb,
  input  sym_t sym_in,
  input  logic emit,
  output sym_t par_out,
  output logic par_idle
);

  localparam gen_t GEN = gen_poly();

  sym_t [PAR_N-1:0] par_q, par_d;
  sym_t             fb;

  // Next-state logic: division by the generator, or shift-out of the remainder
  always_comb begin
    fb    = sym_in ^ par_q[PAR_N-1];
    par_d = par_q;
    if (absorb) begin
      par_d[0] = gf_mul(fb, GEN[0]);
      for (int j = 1; j < PAR_N; j++) begin
        par_d[j] = par_q[j-1] ^ gf_mul(fb, GEN[j]);
      end
    end else if (emit) begin
      par_d[0] = '0;
      for (int j = 1; j < PAR_N; j++) begin
        par_d[j] = par_q[j-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q <= '0;
    end else if (absorb || emit) begin
      par_q <= par_d;
    end
  end

  assign par_out  = par_q[PAR_N-1];
  assign par_idle = (par_q == '0);

  // R4
  one_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(absorb && emit));

endmodule

// File: rtl/rsfec_encoder.sv
module rsfec_encoder
  import rsfec_pkg::*;
#(
  parameter int BLK_W = 257,
  parameter int BLKS  = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [BLK_W-1:0] in_block,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [SYM_W-1:0] out_sym
);

  // The message must fill a whole number of symbols
  localparam int MSG_N = (BLK_W * BLKS) / SYM_W;
  localparam int CW_N  = MSG_N + PAR_N;
  localparam int IDX_W = $clog2(CW_N);

  logic             rst_meta_q, rst_sync_n;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             in_par, fire, cw_end;
  logic             pk_valid, pk_pop;
  sym_t             pk_sym, par_sym;
  logic             par_idle;

  // Reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // Sequencing of message and parity symbols
  always_comb begin
    in_par    = (idx_q >= IDX_W'(MSG_N));
    out_valid = in_par ? 1'b1 : pk_valid;
    out_sym   = in_par ? par_sym : pk_sym;
    fire      = out_valid && out_ready;
    pk_pop    = out_ready && !in_par;
    cw_end    = fire && (idx_q == IDX_W'(CW_N - 1));
    idx_d     = idx_q;
    if (fire) idx_d = cw_end ? '0 : (idx_q + IDX_W'(1));
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      idx_q <= '0;
    end else if (fire) begin
      idx_q <= idx_d;
    end
  end

  rsfec_packer #(
    .BLK_W (BLK_W),
    .BLKS  (BLKS)
  ) u_packer (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .blk_valid (in_valid),
    .blk_ready (in_ready),
    .blk_data  (in_block),
    .sym_valid (pk_valid),
    .sym_data  (pk_sym),
    .sym_pop   (pk_pop),
    .cw_end    (cw_end)
  );

  rsfec_parity_lfsr u_parity (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .absorb   (fire && !in_par),
    .sym_in   (pk_sym),
    .emit     (fire && in_par),
    .par_out  (par_sym),
    .par_idle (par_idle)
  );

  // R5
  par_block_in_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_par |-> !in_ready);

  // R2
  par_no_msg_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_par |-> !pk_valid);

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sym)));

  // R8
  fresh_rem_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cw_end |=> par_idle);

endmodule

// File: tb/rsfec_encoder_test.sv
module rsfec_encoder_test;

  localparam int BLK_W = 257;
  localparam int BLKS  = 20;
  localparam int MSG_B = BLK_W * BLKS;
  localparam int MSG_N = MSG_B / 10;
  localparam int CW_N  = MSG_N + 14;
  localparam int N_CW  = 7;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [BLK_W-1:0] in_block = '0;
  logic             out_valid;
  logic             out_ready = 1'b1;
  logic [9:0]       out_sym;

  int checks = 0;
  int fails  = 0;
  bit stall  = 1'b0;
  bit live   = 1'b0;
  bit done   = 1'b0;

  logic [9:0] exp_q[$];
  int         kind_q[$];
  logic [MSG_B-1:0] msgbits;

  always #5 clk = ~clk;

  rsfec_encoder uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_block  (in_block),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_sym   (out_sym)
  );

  // Bench field arithmetic: LSB-first multiply with x-times reduction
  function automatic logic [9:0] fmul(logic [9:0] a, logic [9:0] b);
    logic [9:0] r, s;
    r = '0;
    s = a;
    for (int i = 0; i < 10; i++) begin
      if (b[i]) r = r ^ s;
      s = s[9] ? ({s[8:0], 1'b0} ^ 10'h009) : {s[8:0], 1'b0};
    end
    return r;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Output ready pattern
  always @(posedge clk) begin
    #1;
    out_ready = stall ? ($urandom % 3 != 0) : 1'b1;
  end

  // Driver: builds a message, queues expected symbols, sends 20 blocks
  task automatic send_cw(int kind, int gaps);
    case (kind)
      0: for (int w = 0; w < MSG_B; w += 32) begin
           logic [31:0] r;
           r = $urandom;
           for (int b = 0; b < 32 && w + b < MSG_B; b++) msgbits[w+b] = r[b];
         end
      1: msgbits = '0;
      2: ;
      3: msgbits = '1;
      default: begin
        msgbits = '0;
        for (int i = 0; i < BLKS; i++) msgbits[i*BLK_W] = 1'b1;
      end
    endcase
    kind_q.push_back(kind);
    for (int k = 0; k < MSG_N; k++) exp_q.push_back(msgbits[k*10 +: 10]);
    for (int i = 0; i < BLKS; i++) begin
      in_block = msgbits[i*BLK_W +: BLK_W];
      in_valid = 1'b1;
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      #1;
      in_valid = 1'b0;
      for (int g = 0; g < gaps; g++) begin
        @(posedge clk);
        #1;
      end
    end
  endtask

  // Monitor / scoreboard
  int         pos = 0;
  int         acc_blocks = 0;
  int         cw_seen = 0;
  bit         prev_stall = 1'b0;
  logic [9:0] prev_sym = '0;
  logic [9:0] syn [14];
  logic [9:0] apow[14];
  logic [9:0] par [14];
  logic [9:0] last_par[14];

  initial begin
    apow[0] = 10'd1;
    for (int i = 1; i < 14; i++) apow[i] = fmul(apow[i-1], 10'd2);
    for (int i = 0; i < 14; i++) begin
      syn[i] = '0;
      last_par[i] = '0;
      par[i] = '0;
    end
  end

  always @(negedge clk) begin
    if (live) begin
      if (prev_stall) begin
        // R6: held offer keeps valid and value
        check(out_valid && out_sym == prev_sym, "R6", "held symbol", int'(out_sym), int'(prev_sym));
      end
      prev_stall = out_valid && !out_ready;
      prev_sym   = out_sym;
      if (in_valid && in_ready) acc_blocks++;
      if (pos >= MSG_N) begin
        // R5: no block taken during parity
        check(!in_ready, "R5", "in_ready during parity", int'(in_ready), 0);
      end
      if (out_valid && out_ready) begin
        if (pos < MSG_N) begin
          logic [9:0] e;
          e = (exp_q.size() > 0) ? exp_q.pop_front() : 10'h3ff;
          // R3: packed message symbol
          check(out_sym == e, "R3", $sformatf("message symbol %0d", pos), int'(out_sym), int'(e));
        end else begin
          par[pos - MSG_N] = out_sym;
        end
        for (int i = 0; i < 14; i++) syn[i] = fmul(syn[i], apow[i]) ^ out_sym;
        pos++;
        if (pos == CW_N) begin
          int kind;
          kind = (kind_q.size() > 0) ? kind_q.pop_front() : -1;
          for (int i = 0; i < 14; i++) begin
            // R4: syndromes vanish
            check(syn[i] == '0, "R4", $sformatf("syndrome %0d", i), int'(syn[i]), 0);
            syn[i] = '0;
          end
          // R2 / R5: 20 blocks per 528-symbol codeword
          check(acc_blocks == BLKS, "R5", "blocks per codeword", acc_blocks, BLKS);
          check(exp_q.size() == 0 || exp_q.size() == MSG_N, "R2", "message length", exp_q.size(), 0);
          if (kind == 1) begin
            for (int i = 0; i < 14; i++)
              check(par[i] == '0, "R7", "zero message parity", int'(par[i]), 0);
          end
          if (kind == 2) begin
            for (int i = 0; i < 14; i++)
              check(par[i] == last_par[i], "R8", "repeated message parity", int'(par[i]), int'(last_par[i]));
          end
          for (int i = 0; i < 14; i++) last_par[i] = par[i];
          acc_blocks = 0;
          pos = 0;
          cw_seen++;
        end
      end
    end
  end

  // Watchdog
  initial begin
    #(10 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d codewords expected %0d", cw_seen, N_CW);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
    live = 1'b1;
    @(posedge clk);
    #1;
    send_cw(0, 0);
    send_cw(1, 1);
    stall = 1'b1;
    send_cw(0, 0);
    send_cw(2, 2);
    stall = 1'b0;
    send_cw(3, 0);
    stall = 1'b1;
    send_cw(4, 0);
    stall = 1'b0;
    send_cw(0, 3);
    while (cw_seen < N_CW) @(posedge clk);
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R2", "idle after last codeword", int'(out_valid), 0);
    done = 1'b1;
    finish_run();
  end

endmodule